// File: doc/BRIEF.md
# PCM Sample Replay Engine

This block plays a stored stream of 8-bit signed PCM sample bytes to an audio output. Software writes a 24-bit start address and a 24-bit end address, picks mono or stereo and one of four sample rates, then sets the enable bit. The engine reads bytes from memory over a simple request/acknowledge port, keeps up to two of them in a small buffer, and presents one sample pair on each tick of its rate divider. The end address is exclusive: the last byte played sits at end minus one.

In one-shot mode, fetching stops when the pointer reaches the end address. The enable bit clears by itself once the buffered bytes have been played. In repeat mode, the pointer jumps back to the start address and playback runs on without a gap. Start and end are copied into working registers only when playback starts or when the loop wraps. Software can therefore queue the next buffer while the current one plays. An end-of-buffer pulse marks each arrival at the end address. An underrun flag records any tick at which memory had not yet delivered the needed bytes.

Top module: `pcm_replay`

## Requirements
- R1: Register map (4-bit offset): 0 control, 1 mode, 2/3/4 start address high/mid/low byte, 5/6/7 live fetch pointer high/mid/low byte (read-only), 8/9/10 end address high/mid/low byte. Written bytes read back unchanged, and unused offsets read 0.
- R2: Control bit 0 is the enable bit. A 0-to-1 write starts fetching at the start address. Writing 0x00 stops playback: memReq falls and no further sampleStrobe occurs.
- R3: In one-shot mode (control bit 1 = 0), each byte from start to end-1 is played exactly once and in order. After the last one, control bit 0 reads 0 and the fetch pointer reads the end address.
- R4: In repeat mode (control bit 1 = 1), the byte after end-1 is taken from the start address and playback stays enabled. A start address written during playback takes effect from the next wrap.
- R5: endIrq is a one-cycle pulse each time a fetched byte brings the pointer to the end address, in both modes.
- R6: Mode bit 7 = 1 selects mono, where each strobe puts the next byte on both channels. Mode bit 7 = 0 selects stereo, where each strobe puts the next byte on the left channel and the byte after it on the right channel.
- R7: Mode bits 1:0 hold the rate code c. sampleStrobe repeats every TICK_UNIT*(8>>c) clock cycles, so codes 0..3 give rates in the ratio 1:2:4:8.
- R8: If a tick finds too few buffered bytes while fetching is still under way, sampleStrobe still fires, both sample outputs hold their values, and underrun goes to 1. A new start clears underrun.
- R9: While memReq is high and memAck is low, memAddr holds still. Each memAck accepts exactly one byte.
- R10: Control reads back enable in bit 0 and repeat in bit 1. The mode register reads back the byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| memReq | output | 1 | Memory byte read request |
| memAddr | output | 24 | Byte address of the request |
| memAck | input | 1 | Memory has returned the byte |
| memData | input | 8 | Returned byte, valid with memAck |
| sampleLeft | output | 8 | Left (or mono) sample |
| sampleRight | output | 8 | Right (or mono) sample |
| sampleStrobe | output | 1 | One-cycle pulse on each new sample pair |
| endIrq | output | 1 | End-of-buffer pulse |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The embedded assertions check the per-cycle rules on every cycle: the memory address holds while a request waits, the buffer fill stays in bounds, two ticks never fall on adjacent cycles, endIrq follows an accepted byte, strobes appear only during playback, and underrun rises only at a strobe with the outputs held. Only the bench scenarios can show the end-to-end behaviour. These scenarios cover the byte order and channel assignment for every rate and channel mode, the exact strobe spacing per rate code, one-shot self-stop with the final pointer value, repeat wrap onto a start address rewritten mid-play, stop on a 0x00 write, and underrun recovery on restart.

// File: rtl/pcm_replay_pkg.sv
package pcm_replay_pkg;
  localparam int ADDR_W     = 24;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int SAMPLE_W   = 8;
  localparam int REG_AW     = 4;

  localparam int OFS_CTRL = 0;
  localparam int OFS_MODE = 1;
  localparam int OFS_BASE = 2;
  localparam int OFS_CUR  = 5;
  localparam int OFS_END  = 8;

  typedef struct packed {
    logic start;
    logic tick;
    logic playing;
    logic stereo;
    logic repeatOn;
  } ctrlStrobes_t;
endpackage

// File: rtl/pcm_replay_ctrl.sv
module pcm_replay_ctrl
  import pcm_replay_pkg::*;
#(
  parameter int TICK_UNIT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic                drained,
  output logic [ADDR_W-1:0]   baseReg,
  output logic [ADDR_W-1:0]   endReg,
  output ctrlStrobes_t        cs
);
  localparam int CNT_W = $clog2(TICK_UNIT * 8);

  logic             playing, repeatOn;
  logic [7:0]       modeReg;
  logic [CNT_W-1:0] divCnt, periodM1;
  logic             ctrlWrite, startNow, tickNow;

  assign ctrlWrite = regWr && (regAddr == REG_AW'(OFS_CTRL));
  assign startNow  = ctrlWrite && regWdata[0] && !playing;
  assign periodM1  = CNT_W'((TICK_UNIT << (3 - int'(modeReg[1:0]))) - 1);
  assign tickNow   = playing && (divCnt >= periodM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      playing  <= 1'b0;
      repeatOn <= 1'b0;
      modeReg  <= '0;
      baseReg  <= '0;
      endReg   <= '0;
      divCnt   <= '0;
    end else begin
      if (drained) playing <= 1'b0;
      if (regWr) begin
        if (regAddr == REG_AW'(OFS_CTRL)) begin
          playing  <= regWdata[0];
          repeatOn <= regWdata[1];
        end
        if (regAddr == REG_AW'(OFS_MODE)) modeReg <= regWdata;
        for (int i = 0; i < ADDR_BYTES; i++) begin
          if (regAddr == REG_AW'(OFS_BASE + i))
            baseReg[8*(ADDR_BYTES-1-i) +: 8] <= regWdata;
          if (regAddr == REG_AW'(OFS_END + i))
            endReg[8*(ADDR_BYTES-1-i) +: 8] <= regWdata;
        end
      end
      if (startNow || !playing || tickNow) divCnt <= '0;
      else divCnt <= divCnt + CNT_W'(1);
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_AW'(OFS_CTRL)) regRdata = {6'b0, repeatOn, playing};
    if (regAddr == REG_AW'(OFS_MODE)) regRdata = modeReg;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (regAddr == REG_AW'(OFS_BASE + i)) regRdata = baseReg[8*(ADDR_BYTES-1-i) +: 8];
      if (regAddr == REG_AW'(OFS_CUR + i))  regRdata = curAddr[8*(ADDR_BYTES-1-i) +: 8];
      if (regAddr == REG_AW'(OFS_END + i))  regRdata = endReg[8*(ADDR_BYTES-1-i) +: 8];
    end
  end

  always_comb begin
    cs.start    = startNow;
    cs.tick     = tickNow;
    cs.playing  = playing;
    cs.stereo   = !modeReg[7];
    cs.repeatOn = repeatOn;
  end

  // R7: with TICK_UNIT >= 2 the fastest period is at least two cycles
  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    tickNow |=> !tickNow);

  initial assert (TICK_UNIT >= 2) else $error("TICK_UNIT must be at least 2");
endmodule

// File: rtl/pcm_replay_dp.sv
module pcm_replay_dp
  import pcm_replay_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        cs,
  input  logic [ADDR_W-1:0]   baseReg,
  input  logic [ADDR_W-1:0]   endReg,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic                memAck,
  input  logic [SAMPLE_W-1:0] memData,
  output logic [SAMPLE_W-1:0] sampleLeft,
  output logic [SAMPLE_W-1:0] sampleRight,
  output logic                sampleStrobe,
  output logic                endIrq,
  output logic                underrun,
  output logic [ADDR_W-1:0]   curAddr,
  output logic                drained
);
  logic [ADDR_W-1:0]   ptr, endWork, nextPtr;
  logic [SAMPLE_W-1:0] slot0, slot1, n0, n1;
  logic [1:0]          count, nCount, need;
  logic                fetchDone, push, pop, enough, atEnd;

  assign need    = cs.stereo ? 2'd2 : 2'd1;
  assign enough  = count >= need;
  assign memReq  = cs.playing && !fetchDone && (count < 2'd2);
  assign memAddr = ptr;
  assign curAddr = ptr;
  assign push    = memReq && memAck;
  assign pop     = cs.tick && enough;
  assign nextPtr = ptr + ADDR_W'(1);
  assign atEnd   = nextPtr == endWork;
  assign drained = cs.tick && fetchDone && !enough;

  always_comb begin
    n0 = slot0;
    n1 = slot1;
    nCount = count;
    if (pop) begin
      if (cs.stereo) nCount = 2'd0;
      else begin
        n0 = slot1;
        nCount = count - 2'd1;
      end
    end
    if (push) begin
      if (nCount == 2'd0) n0 = memData;
      else n1 = memData;
      nCount = nCount + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0; endWork <= '0; slot0 <= '0; slot1 <= '0; count <= '0;
      fetchDone <= 1'b0; underrun <= 1'b0; sampleStrobe <= 1'b0; endIrq <= 1'b0;
      sampleLeft <= '0; sampleRight <= '0;
    end else if (cs.start) begin
      ptr <= baseReg; endWork <= endReg; count <= '0;
      fetchDone <= 1'b0; underrun <= 1'b0; sampleStrobe <= 1'b0; endIrq <= 1'b0;
    end else begin
      slot0 <= n0;
      slot1 <= n1;
      count <= nCount;
      endIrq <= push && atEnd;
      if (push) begin
        if (atEnd && cs.repeatOn) begin
          ptr <= baseReg;
          endWork <= endReg;
        end else begin
          ptr <= nextPtr;
          if (atEnd) fetchDone <= 1'b1;
        end
      end
      sampleStrobe <= cs.tick && !(fetchDone && !enough);
      if (pop) begin
        sampleLeft  <= slot0;
        sampleRight <= cs.stereo ? slot1 : slot0;
      end
      if (cs.tick && !enough && !fetchDone) underrun <= 1'b1;
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    count <= 2'd2);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (!memReq || $stable(memAddr)));
  assert_irq_after_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    endIrq |-> $past(memReq && memAck));
  assert_strobe_in_play_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(cs.playing));
  assert_underrun_at_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> (sampleStrobe && $stable(sampleLeft) && $stable(sampleRight)));
endmodule

// File: rtl/pcm_replay.sv
module pcm_replay
  import pcm_replay_pkg::*;
#(
  parameter int TICK_UNIT = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWr,
  input  logic [3:0]   regAddr,
  input  logic [7:0]   regWdata,
  output logic [7:0]   regRdata,
  output logic         memReq,
  output logic [23:0]  memAddr,
  input  logic         memAck,
  input  logic [7:0]   memData,
  output logic [7:0]   sampleLeft,
  output logic [7:0]   sampleRight,
  output logic         sampleStrobe,
  output logic         endIrq,
  output logic         underrun
);
  ctrlStrobes_t      cs;
  logic [ADDR_W-1:0] baseReg, endReg, curAddr;
  logic              drained;

  pcm_replay_ctrl #(.TICK_UNIT(TICK_UNIT)) ctrlInst (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .curAddr(curAddr),
    .drained(drained), .baseReg(baseReg), .endReg(endReg), .cs(cs)
  );

  pcm_replay_dp dpInst (
    .clk(clk), .rstN(rstN), .cs(cs), .baseReg(baseReg), .endReg(endReg),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sampleStrobe(sampleStrobe), .endIrq(endIrq), .underrun(underrun),
    .curAddr(curAddr), .drained(drained)
  );
endmodule

// File: tb/pcm_replay_test.sv
module pcm_replay_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_UNIT  = 4;

  logic clk = 0, rstN = 0, regWr = 0, memAck = 0;
  logic [3:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata, memData = 0, sampleLeft, sampleRight;
  logic memReq, sampleStrobe, endIrq, underrun;
  logic [23:0] memAddr;

  int checks = 0, fails = 0, cyc = 0;
  int nStrobes = 0, rawStrobes = 0, nIrq = 0, prevCyc = 0, expPeriod = 0;
  bit monOn = 0, havePrev = 0, ackOn = 1, stereoMode = 0;
  logic [23:0] expAddr, expEnd, loopBase;

  pcm_replay #(.TICK_UNIT(TICK_UNIT)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] stepA(logic [23:0] a);
    logic [23:0] n = a + 24'd1;
    return (n == expEnd) ? loopBase : n;
  endfunction

  always @(negedge clk) begin
    memAck  <= ackOn && memReq;
    memData <= pat(memAddr);
    if (endIrq) nIrq++;
    if (sampleStrobe) begin
      rawStrobes++;
      if (monOn) begin
        logic [7:0] eL, eR;
        eL = pat(expAddr); expAddr = stepA(expAddr);
        if (stereoMode) begin eR = pat(expAddr); expAddr = stepA(expAddr); end
        else eR = eL;
        check(sampleLeft == eL, "R6 left/mono sample", sampleLeft, eL);
        check(sampleRight == eR, "R6 right sample", sampleRight, eR);
        if (havePrev) check(cyc - prevCyc == expPeriod, "R7 strobe period", cyc - prevCyc, expPeriod);
        havePrev = 1; prevCyc = cyc; nStrobes++;
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); regWr = 1; regAddr = 4'(a); regWdata = 8'(d);
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk); regAddr = 4'(a); #1 v = regRdata;
  endtask

  task automatic setAddrs(logic [23:0] b, logic [23:0] e);
    wr(2, b[23:16]); wr(3, b[15:8]); wr(4, b[7:0]);
    wr(8, e[23:16]); wr(9, e[15:8]); wr(10, e[7:0]);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    logic [7:0] v, heldL;
    logic [23:0] b, e, cur;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    rd(0, v); check(v == 0, "R10 control after reset", v, 0);
    check(memReq == 0 && sampleStrobe == 0 && underrun == 0, "R2 idle after reset", memReq, 0);

    // R1 register readback
    setAddrs(24'hA1B2C3, 24'h0D0E0F);
    rd(2, v); check(v == 8'hA1, "R1 start high", v, 8'hA1);
    rd(3, v); check(v == 8'hB2, "R1 start mid", v, 8'hB2);
    rd(4, v); check(v == 8'hC3, "R1 start low", v, 8'hC3);
    rd(8, v); check(v == 8'h0D, "R1 end high", v, 8'h0D);
    rd(10, v); check(v == 8'h0F, "R1 end low", v, 8'h0F);
    rd(12, v); check(v == 0, "R1 unused offset", v, 0);
    wr(1, 8'h83); rd(1, v); check(v == 8'h83, "R10 mode readback", v, 8'h83);

    // R3 R5 R6 R7 sweep over rate code and channel mode, one-shot
    for (int combo = 0; combo < 8; combo++) begin
      int rate = combo % 4;
      bit st = combo >= 4;
      b = 24'h123400 + 24'(combo * 16);
      e = b + 24'd6;
      setAddrs(b, e);
      wr(1, {~st, 5'b0, 2'(rate)});
      stereoMode = st; expAddr = b; expEnd = e; loopBase = b;
      expPeriod = TICK_UNIT * (8 >> rate);
      nStrobes = 0; nIrq = 0; havePrev = 0; monOn = 1;
      wr(0, 8'h01);
      for (int k = 0; k < expPeriod * 10 + 40; k++) begin
        rd(0, v);
        if (!v[0]) break;
      end
      check(v[0] == 0, "R3 enable self-clears", v, 0);
      check(nStrobes == (st ? 3 : 6), "R6 strobe count", nStrobes, st ? 3 : 6);
      check(nIrq == 1, "R5 one end pulse one-shot", nIrq, 1);
      rd(5, v); cur[23:16] = v; rd(6, v); cur[15:8] = v; rd(7, v); cur[7:0] = v;
      check(cur == e, "R3 pointer at end", cur, e);
      monOn = 0;
    end

    // R4 repeat with mid-play start rewrite, then R2 stop
    setAddrs(24'h000200, 24'h000206);
    wr(1, 8'h83);
    stereoMode = 0; expAddr = 24'h000200; expEnd = 24'h000206; loopBase = 24'h000200;
    expPeriod = TICK_UNIT; nStrobes = 0; nIrq = 0; havePrev = 0; monOn = 1;
    wr(0, 8'h03);
    wr(4, 8'h04); loopBase = 24'h000204;
    for (int k = 0; k < 200 && nStrobes < 12; k++) @(negedge clk);
    rd(0, v); check(v == 8'h03, "R4 still enabled in repeat", v, 3);
    check(nIrq >= 4, "R5 end pulses each loop", nIrq, 4);
    wr(0, 8'h00);
    monOn = 0;
    repeat (2) @(negedge clk);
    rawStrobes = 0;
    repeat (40) @(negedge clk);
    check(rawStrobes == 0, "R2 no strobe after stop", rawStrobes, 0);
    check(memReq == 0, "R2 request dropped after stop", memReq, 0);

    // R8 underrun: memory silent
    heldL = sampleLeft;
    ackOn = 0; rawStrobes = 0;
    wr(0, 8'h01);
    repeat (TICK_UNIT * 3 + 4) @(negedge clk);
    check(rawStrobes >= 3, "R8 strobe still fires", rawStrobes, 3);
    check(underrun == 1, "R8 underrun set", underrun, 1);
    check(sampleLeft == heldL, "R8 output held", sampleLeft, heldL);
    check(memReq == 1, "R9 request waits for ack", memReq, 1);
    ackOn = 1;
    wr(0, 8'h00);
    wr(0, 8'h01);
    repeat (2) @(negedge clk);
    check(underrun == 0, "R8 cleared at start", underrun, 0);
    wr(0, 8'h00);
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule